// File: doc/BRIEF.md
# Conflict-Free Banked Scratchpad

This block is an on-chip scratchpad that holds one N-point polynomial while an iterated transform runs over it. The storage is split into P banks, each N/P words deep. Every cycle it can accept P element writes and P element reads. Either side uses one of two access patterns. The first is a pairing pattern: half the lanes take consecutive elements from the lower half of the polynomial, and the other half take the partners that sit N/2 further on. The second is plain sequential order. The iteration index picks the pattern: the first half of the iterations pair, the rest run sequentially.

Each element address is turned into a bank and a row. The bank is the low address bits XORed with a fold of the row bits. The fold is aligned so that the top address bit always lands on the most significant bank bit. With this mapping, both patterns reach P distinct banks in every cycle, and no re-layout pass is needed between iterations. A permutation network on the write side sends each lane to its bank. A second one on the read side returns the bank outputs in lane order.

A sequential burst port moves P elements per beat between the banks and external memory. It has its own load and store beat counters. Results of one iteration stay in the banks for the next.

Top module: `banked_scratchpad`

## Requirements
- R1: After reset, `lane_rd_valid` and `burst_st_valid` are low, and the burst load and store beat counters both start at beat 0.
- R2: A lane access with iteration index below ITERS/2 uses the pairing pattern. For round r, lane k (k < P/2) maps to element r·(P/2)+k, and lane k (k ≥ P/2) maps to element r·(P/2)+(k−P/2)+N/2. Any other iteration index uses sequential order, where lane k of round r maps to element r·P+k.
- R3: In every cycle, the P write lanes address P distinct banks and the P read lanes address P distinct banks, for both patterns and for burst beats.
- R4: A lane read returns, in lane k, the last value written to lane k's element, whatever pattern the writer used.
- R5: A lane read requested in cycle t (with no burst store in that cycle) raises `lane_rd_valid` and presents its data in cycle t+1. No lane read request means no `lane_rd_valid` in the next cycle.
- R6: Burst load beat b writes lane k of `burst_ld_data` to element b·P+k. The beat counter advances by one per beat and wraps to 0 after N/P beats.
- R7: A burst store request in cycle t returns, in cycle t+1, elements b·P..b·P+P−1 of the current store beat b in lane order, with `burst_st_valid` high. The store counter wraps after N/P beats.
- R8: When a burst load beat and a lane write occur in the same cycle, the burst load is performed and the lane write has no effect.
- R9: When a burst store request and a lane read occur in the same cycle, the store is served and the lane read is dropped (`lane_rd_valid` stays low in the next cycle).
- R10: A read and a write to the same element in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_wr_en | input | 1 | Lane write request |
| lane_wr_iter | input | $clog2(ITERS) | Iteration index of the write, selects its pattern |
| lane_wr_round | input | $clog2(N/P) | Round within the iteration for the write |
| lane_wr_data | input | P·W | Write data, lane k in bits k·W +: W |
| lane_rd_en | input | 1 | Lane read request |
| lane_rd_iter | input | $clog2(ITERS) | Iteration index of the read, selects its pattern |
| lane_rd_round | input | $clog2(N/P) | Round within the iteration for the read |
| burst_ld_valid | input | 1 | Sequential burst load beat |
| burst_ld_data | input | P·W | Burst load data, lane k in bits k·W +: W |
| burst_st_req | input | 1 | Sequential burst store beat request |
| rd_data | output | P·W | Read data for lane reads and burst stores, lane order |
| lane_rd_valid | output | 1 | `rd_data` carries a lane read result |
| burst_st_valid | output | 1 | `rd_data` carries a burst store beat |

## Verification
The hardest case to reach from the ports is one where the two sides of the banks work in different patterns in the same cycle: a pairing-order read of the elements that a sequential-order write is updating, or the reverse, while burst beats cut into the lane traffic. Reaching it takes more than reading back data. The bench first fills the whole polynomial with burst loads. It then rewrites the polynomial in one pattern and reads it in the other. Next, it issues reads and writes to the same rounds in the same cycle, so that read-before-write order becomes visible. Finally, it forces burst and lane requests to collide, and runs a long random mix of iterations, rounds and enables against a behavioural element-array model.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic {
        PAT_PAIR = 1'b0,
        PAT_SEQ  = 1'b1
    } sp_pattern_e;

endpackage

// File: rtl/sp_addr_map.sv
// Per-lane element address, skewed bank index and row, plus the inverse
// bank-to-lane map used to steer the write permutation.
module sp_addr_map
    import sp_pkg::*;
#(
    parameter int N = 64,
    parameter int P = 4,
    localparam int AW  = $clog2(N),
    localparam int L   = $clog2(P),
    localparam int R   = AW - L,
    localparam int PAD = (L - (R % L)) % L,
    localparam int RX  = R + PAD,
    localparam int NCH = RX / L
) (
    input  sp_pattern_e          pat,
    input  logic [R-1:0]         round,
    output logic [P-1:0][L-1:0]  lane_bank,
    output logic [P-1:0][R-1:0]  bank_row,
    output logic [P-1:0][L-1:0]  bank_lane
);

    logic [P-1:0][R-1:0] lane_row;

    // Fold of the row bits, padded at the bottom so the top row bit lands
    // on the most significant bank bit.
    function automatic logic [L-1:0] row_fold(input logic [R-1:0] row);
        logic [RX-1:0] ext;
        logic [L-1:0]  f;
        ext = RX'(row) << PAD;
        f   = '0;
        for (int c = 0; c < NCH; c++) begin
            f = f ^ ext[c*L +: L];
        end
        return f;
    endfunction

    always_comb begin
        logic [AW-1:0] a;
        lane_bank = '0;
        lane_row  = '0;
        for (int k = 0; k < P; k++) begin
            if (pat == PAT_PAIR) begin
                a = AW'(round) << (L - 1);
                a = a | AW'(k % (P / 2));
                if (k >= P / 2) begin
                    a[AW-1] = 1'b1;
                end
            end else begin
                a = {round, L'(k)};
            end
            lane_row[k]  = a[AW-1:L];
            lane_bank[k] = a[L-1:0] ^ row_fold(a[AW-1:L]);
        end
    end

    always_comb begin
        bank_row  = '0;
        bank_lane = '0;
        for (int b = 0; b < P; b++) begin
            for (int k = 0; k < P; k++) begin
                if (lane_bank[k] == L'(b)) begin
                    bank_row[b]  = lane_row[k];
                    bank_lane[b] = L'(k);
                end
            end
        end
    end

endmodule

// File: rtl/sp_xbar.sv
// P x P selection network: output i takes input sel[i].
module sp_xbar #(
    parameter int W = 16,
    parameter int P = 4,
    localparam int L = $clog2(P)
) (
    input  logic [P-1:0][W-1:0] din,
    input  logic [P-1:0][L-1:0] sel,
    output logic [P-1:0][W-1:0] dout
);

    always_comb begin
        for (int i = 0; i < P; i++) begin
            dout[i] = din[sel[i]];
        end
    end

endmodule

// File: rtl/sp_bank.sv
// One simple dual-port bank with a registered, read-first output.
module sp_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int RW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [RW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import sp_pkg::*;
#(
    parameter int N     = 64,
    parameter int P     = 4,
    parameter int W     = 16,
    parameter int ITERS = 4,
    localparam int AW = $clog2(N),
    localparam int L  = $clog2(P),
    localparam int R  = AW - L,
    localparam int IW = $clog2(ITERS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lane_wr_en,
    input  logic [IW-1:0]   lane_wr_iter,
    input  logic [R-1:0]    lane_wr_round,
    input  logic [P*W-1:0]  lane_wr_data,
    input  logic            lane_rd_en,
    input  logic [IW-1:0]   lane_rd_iter,
    input  logic [R-1:0]    lane_rd_round,
    input  logic            burst_ld_valid,
    input  logic [P*W-1:0]  burst_ld_data,
    input  logic            burst_st_req,
    output logic [P*W-1:0]  rd_data,
    output logic            lane_rd_valid,
    output logic            burst_st_valid
);

    typedef struct packed {
        logic                rd_valid;
        logic                st_valid;
        logic [R-1:0]        ld_cnt;
        logic [R-1:0]        st_cnt;
        logic [P-1:0][L-1:0] rd_sel;
    } state_t;

    state_t s_d, s_q;

    sp_pattern_e          wr_pat, rd_pat;
    logic [R-1:0]         wr_round, rd_round;
    logic                 wr_go, rd_go;
    logic [P-1:0][W-1:0]  wr_lane_data;
    logic [P-1:0][L-1:0]  wr_lane_bank, wr_bank_lane;
    logic [P-1:0][L-1:0]  rd_lane_bank, rd_bank_lane;
    logic [P-1:0][R-1:0]  wr_bank_row, rd_bank_row;
    logic [P-1:0][W-1:0]  bank_wdata, bank_rdata, lane_rdata;

    // Source selection: burst beats take the port; pattern from iteration.
    always_comb begin
        wr_go = burst_ld_valid | lane_wr_en;
        rd_go = burst_st_req | lane_rd_en;
        if (burst_ld_valid) begin
            wr_pat       = PAT_SEQ;
            wr_round     = s_q.ld_cnt;
            wr_lane_data = burst_ld_data;
        end else begin
            wr_pat       = (lane_wr_iter < IW'(ITERS / 2)) ? PAT_PAIR : PAT_SEQ;
            wr_round     = lane_wr_round;
            wr_lane_data = lane_wr_data;
        end
        if (burst_st_req) begin
            rd_pat   = PAT_SEQ;
            rd_round = s_q.st_cnt;
        end else begin
            rd_pat   = (lane_rd_iter < IW'(ITERS / 2)) ? PAT_PAIR : PAT_SEQ;
            rd_round = lane_rd_round;
        end
    end

    sp_addr_map #(.N(N), .P(P)) u_wr_map (
        .pat       (wr_pat),
        .round     (wr_round),
        .lane_bank (wr_lane_bank),
        .bank_row  (wr_bank_row),
        .bank_lane (wr_bank_lane)
    );

    sp_addr_map #(.N(N), .P(P)) u_rd_map (
        .pat       (rd_pat),
        .round     (rd_round),
        .lane_bank (rd_lane_bank),
        .bank_row  (rd_bank_row),
        .bank_lane (rd_bank_lane)
    );

    sp_xbar #(.W(W), .P(P)) u_wr_xbar (
        .din  (wr_lane_data),
        .sel  (wr_bank_lane),
        .dout (bank_wdata)
    );

    for (genvar b = 0; b < P; b++) begin : g_bank
        sp_bank #(.W(W), .DEPTH(N / P)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_go),
            .waddr (wr_bank_row[b]),
            .wdata (bank_wdata[b]),
            .re    (rd_go),
            .raddr (rd_bank_row[b]),
            .rdata (bank_rdata[b])
        );
    end

    sp_xbar #(.W(W), .P(P)) u_rd_xbar (
        .din  (bank_rdata),
        .sel  (s_q.rd_sel),
        .dout (lane_rdata)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = lane_rd_en & ~burst_st_req;
        s_d.st_valid = burst_st_req;
        if (burst_ld_valid) begin
            s_d.ld_cnt = s_q.ld_cnt + 1'b1;
        end
        if (burst_st_req) begin
            s_d.st_cnt = s_q.st_cnt + 1'b1;
        end
        if (rd_go) begin
            s_d.rd_sel = rd_lane_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data        = lane_rdata;
    assign lane_rd_valid  = s_q.rd_valid;
    assign burst_st_valid = s_q.st_valid;

endmodule

// File: rtl/banked_scratchpad_chk.sv
module banked_scratchpad_chk #(
    parameter int N = 64,
    parameter int P = 4,
    localparam int L = $clog2(P)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lane_rd_en,
    input logic           burst_st_req,
    input logic           lane_rd_valid,
    input logic           burst_st_valid,
    input logic           wr_go,
    input logic           rd_go,
    input logic [P*L-1:0] wr_lane_bank,
    input logic [P*L-1:0] rd_bank_lane
);

    logic [P-1:0] wr_hit, rd_hit;

    always_comb begin
        wr_hit = '0;
        rd_hit = '0;
        for (int k = 0; k < P; k++) begin
            wr_hit[wr_lane_bank[k*L +: L]] = 1'b1;
            rd_hit[rd_bank_lane[k*L +: L]] = 1'b1;
        end
    end

    AST_WR_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> ($countones(wr_hit) == P));                               // R3
    AST_RD_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> ($countones(rd_hit) == P));                               // R3
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_rd_en && !burst_st_req) |=> lane_rd_valid);                   // R5
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_rd_en |=> !lane_rd_valid);                                    // R5
    AST_ST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        burst_st_req |=> burst_st_valid);                                   // R7
    AST_ST_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        burst_st_req |=> !lane_rd_valid);                                   // R9

endmodule

bind banked_scratchpad banked_scratchpad_chk #(.N(N), .P(P)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lane_rd_en     (lane_rd_en),
    .burst_st_req   (burst_st_req),
    .lane_rd_valid  (lane_rd_valid),
    .burst_st_valid (burst_st_valid),
    .wr_go          (wr_go),
    .rd_go          (rd_go),
    .wr_lane_bank   (wr_lane_bank),
    .rd_bank_lane   (rd_bank_lane)
);

// File: tb/banked_scratchpad_test.sv
module banked_scratchpad_test;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 64;
    localparam int P     = 4;
    localparam int W     = 16;
    localparam int ITERS = 4;
    localparam int R     = $clog2(N / P);
    localparam int IW    = $clog2(ITERS);
    localparam int BEATS = N / P;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           lane_wr_en = 1'b0;
    logic [IW-1:0]  lane_wr_iter = '0;
    logic [R-1:0]   lane_wr_round = '0;
    logic [P*W-1:0] lane_wr_data = '0;
    logic           lane_rd_en = 1'b0;
    logic [IW-1:0]  lane_rd_iter = '0;
    logic [R-1:0]   lane_rd_round = '0;
    logic           burst_ld_valid = 1'b0;
    logic [P*W-1:0] burst_ld_data = '0;
    logic           burst_st_req = 1'b0;
    logic [P*W-1:0] rd_data;
    logic           lane_rd_valid;
    logic           burst_st_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    string phase = "R1";

    logic [W-1:0]   mem [N];
    int             ld_cnt = 0;
    int             st_cnt = 0;
    logic           exp_rd_valid = 1'b0;
    logic           exp_st_valid = 1'b0;
    logic [P*W-1:0] exp_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_scratchpad #(.N(N), .P(P), .W(W), .ITERS(ITERS)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lane_wr_en     (lane_wr_en),
        .lane_wr_iter   (lane_wr_iter),
        .lane_wr_round  (lane_wr_round),
        .lane_wr_data   (lane_wr_data),
        .lane_rd_en     (lane_rd_en),
        .lane_rd_iter   (lane_rd_iter),
        .lane_rd_round  (lane_rd_round),
        .burst_ld_valid (burst_ld_valid),
        .burst_ld_data  (burst_ld_data),
        .burst_st_req   (burst_st_req),
        .rd_data        (rd_data),
        .lane_rd_valid  (lane_rd_valid),
        .burst_st_valid (burst_st_valid)
    );

    // R2: element addressed by lane k in a given iteration and round
    function automatic int lane_addr(int iter, int round, int k);
        if (iter < ITERS / 2) begin
            return round * (P / 2) + (k % (P / 2)) + ((k >= P / 2) ? N / 2 : 0);
        end
        return round * P + k;
    endfunction

    function automatic logic [P*W-1:0] mk(int seed);
        logic [P*W-1:0] v;
        for (int k = 0; k < P; k++) begin
            v[k*W +: W] = W'(seed * 131 + k * 17 + 5);
        end
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [P*W-1:0] act, logic [P*W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s) at %0t: actual %h expected %h", tag, phase, $time, act, exp);
        end
    endtask

    // One clock: model reads before writes (R10), then compare at negedge.
    task automatic step();
        @(posedge clk);
        exp_st_valid = burst_st_req;
        exp_rd_valid = lane_rd_en && !burst_st_req;             // R9
        if (burst_st_req) begin
            for (int k = 0; k < P; k++) exp_data[k*W +: W] = mem[st_cnt * P + k];
            st_cnt = (st_cnt + 1) % BEATS;                      // R7
        end else if (lane_rd_en) begin
            for (int k = 0; k < P; k++)
                exp_data[k*W +: W] = mem[lane_addr(int'(lane_rd_iter), int'(lane_rd_round), k)];
        end
        if (burst_ld_valid) begin                               // R8: load wins
            for (int k = 0; k < P; k++) mem[ld_cnt * P + k] = burst_ld_data[k*W +: W];
            ld_cnt = (ld_cnt + 1) % BEATS;                      // R6
        end else if (lane_wr_en) begin
            for (int k = 0; k < P; k++)
                mem[lane_addr(int'(lane_wr_iter), int'(lane_wr_round), k)] = lane_wr_data[k*W +: W];
        end
        @(negedge clk);
        check(lane_rd_valid == exp_rd_valid, "R5 lane_rd_valid", P*W'(lane_rd_valid), P*W'(exp_rd_valid));
        check(burst_st_valid == exp_st_valid, "R7 burst_st_valid", P*W'(burst_st_valid), P*W'(exp_st_valid));
        if (exp_st_valid) check(rd_data === exp_data, "R7 store data", rd_data, exp_data);
        if (exp_rd_valid) check(rd_data === exp_data, "R4 lane data", rd_data, exp_data);
    endtask

    task automatic idle();
        lane_wr_en = 0; lane_rd_en = 0; burst_ld_valid = 0; burst_st_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mem[i] = '0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(lane_rd_valid == 1'b0, "R1 rd_valid in reset", P*W'(lane_rd_valid), '0);
        check(burst_st_valid == 1'b0, "R1 st_valid in reset", P*W'(burst_st_valid), '0);
        rst_n = 1'b1;
        step();

        // R6: fill the polynomial by sequential burst loads starting at beat 0 (R1)
        phase = "R6";
        for (int b = 0; b < BEATS; b++) begin
            idle(); burst_ld_valid = 1; burst_ld_data = mk(100 + b);
            step();
        end
        idle(); step();

        // R7: drain by burst stores
        phase = "R7";
        for (int b = 0; b < BEATS; b++) begin
            idle(); burst_st_req = 1; step();
        end
        idle(); step();

        // R2 R3 R4: read every round in pairing order, then sequential order
        phase = "R2";
        for (int it = 0; it < ITERS; it += ITERS - 1) begin
            for (int r = 0; r < BEATS; r++) begin
                idle(); lane_rd_en = 1; lane_rd_iter = IW'(it); lane_rd_round = R'(r);
                step();
            end
        end
        idle(); step();

        // R4: write in pairing order, read in sequential order, and the reverse
        phase = "R4";
        for (int r = 0; r < BEATS; r++) begin
            idle(); lane_wr_en = 1; lane_wr_iter = 1; lane_wr_round = R'(r);
            lane_wr_data = mk(300 + r); step();
        end
        for (int r = 0; r < BEATS; r++) begin
            idle(); lane_rd_en = 1; lane_rd_iter = 2; lane_rd_round = R'(r); step();
        end
        for (int r = 0; r < BEATS; r++) begin
            idle(); lane_wr_en = 1; lane_wr_iter = 3; lane_wr_round = R'(r);
            lane_wr_data = mk(500 + r); step();
        end
        for (int r = 0; r < BEATS; r++) begin
            idle(); lane_rd_en = 1; lane_rd_iter = 0; lane_rd_round = R'(r); step();
        end
        idle(); step();

        // R10: read and write the same round in the same cycle, then re-read
        phase = "R10";
        for (int r = 0; r < 4; r++) begin
            idle(); lane_wr_en = 1; lane_rd_en = 1;
            lane_wr_iter = 0; lane_rd_iter = 0;
            lane_wr_round = R'(r); lane_rd_round = R'(r);
            lane_wr_data = mk(700 + r); step();
            idle(); lane_rd_en = 1; lane_rd_iter = 0; lane_rd_round = R'(r); step();
        end

        // R8: burst load beat collides with a lane write (beat wraps to 0, R6)
        phase = "R8";
        idle(); burst_ld_valid = 1; burst_ld_data = mk(900);
        lane_wr_en = 1; lane_wr_iter = 0; lane_wr_round = 5; lane_wr_data = mk(901);
        step();
        idle(); lane_rd_en = 1; lane_rd_iter = 0; lane_rd_round = 5; step();
        idle(); lane_rd_en = 1; lane_rd_iter = 2; lane_rd_round = 0; step();

        // R9: burst store beat collides with a lane read
        phase = "R9";
        idle(); burst_st_req = 1; lane_rd_en = 1; lane_rd_iter = 3; lane_rd_round = 2; step();
        idle(); step();

        // R3 R4 R8 R9: random mix of patterns, rounds and collisions
        phase = "R3";
        for (int i = 0; i < 600; i++) begin
            lane_wr_en     = 1'($urandom_range(0, 1));
            lane_rd_en     = 1'($urandom_range(0, 1));
            burst_ld_valid = ($urandom_range(0, 7) == 0);
            burst_st_req   = ($urandom_range(0, 7) == 0);
            lane_wr_iter   = IW'($urandom_range(0, ITERS - 1));
            lane_rd_iter   = IW'($urandom_range(0, ITERS - 1));
            lane_wr_round  = R'($urandom_range(0, BEATS - 1));
            lane_rd_round  = R'($urandom_range(0, BEATS - 1));
            lane_wr_data   = mk(int'($urandom_range(0, 60000)));
            burst_ld_data  = mk(int'($urandom_range(0, 60000)));
            step();
        end
        idle(); step();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule